// File: doc/BRIEF.md
# Temperature Alert Engine

This block turns a stream of converted temperature results into an alert line and an alert status bit. Each result is a 16-bit two's-complement value with 1/128 °C per LSB, presented for one cycle with a valid strobe. A hysteretic tracker compares the result with a high and a low threshold. It changes state only after a programmable number of consecutive results, from one to four, meet the condition it is currently watching.

Two alert modes are supported. In comparator mode the alert line follows the tracker directly. In interrupt mode every change of tracker state latches the alert. The latch is cleared by any register read, or when sleep mode is entered. Because the tracker keeps running, the next latch after a high event comes only from the low threshold, and the reverse after a low event. The line polarity is programmable. The mode bit is held inside the block, because a general-reset event must clear it and force comparator mode.

Top module: `thermal_alert`

## Requirements
- R1: After reset, the alert line is inactive, the status bit reads 1 (inactive at polarity 0) and the mode output reads 0 (comparator).
- R2: The fault-count field selects the number of consecutive results needed as 00=1, 01=2, 10=3, 11=4. The tracker changes on exactly that result.
- R3: A valid result that does not meet the watched condition returns the consecutive count to zero.
- R4: In comparator mode (mode 0), the alert becomes active after N results at or above the high threshold. It stays active through results between the thresholds, and becomes inactive after N results at or below the low threshold.
- R5: In interrupt mode (mode 1), a tracker change latches the alert active. Any register read clears the latch on the next edge.
- R6: In interrupt mode, once the tracker has gone high, more high results raise no new alert. The next alert comes only from N results at or below the low threshold.
- R7: The rising edge of the sleep input clears an interrupt-mode alert. Holding sleep high does not clear alerts raised later.
- R8: With polarity 0 the alert line is active-low. With polarity 1 it is active-high.
- R9: The status bit is the tracker state mapped through the polarity. In comparator mode it equals the alert line.
- R10: Comparisons are signed and inclusive. For example, 0xEC00 (−40 °C) is below a high threshold of 0x0010, and a result equal to a threshold meets that threshold.
- R11: A general-reset pulse clears the mode bit. Any change of the mode bit clears the consecutive count, the tracker and the interrupt latch.
- R12: If a read and a tracker change fall in the same cycle, the alert ends up active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_im_wr | input | 1 | Write strobe for the mode bit |
| cfg_im_wdata | input | 1 | New mode bit: 0 comparator, 1 interrupt |
| cfg_pol | input | 1 | Alert polarity: 0 active-low, 1 active-high |
| cfg_cf | input | 2 | Consecutive result count selector |
| cfg_sleep | input | 1 | Sleep mode level; its rising edge clears the interrupt latch |
| thr_low | input | 16 | Low threshold, signed |
| thr_high | input | 16 | High threshold, signed |
| res_valid | input | 1 | One-cycle strobe for a new result |
| res_value | input | 16 | Conversion result, signed, 1/128 °C per LSB |
| reg_read | input | 1 | Pulse marking any register read |
| gen_reset | input | 1 | General-reset event pulse |
| alert_pin | output | 1 | Alert line level |
| alert_status | output | 1 | Alert status bit |
| im_mode | output | 1 | Current mode bit |

## Verification
A register read that clears the interrupt latch can fall in the same cycle as a result that completes a tracker change. The bench provokes this by raising the read pulse and the result strobe in one cycle. It then expects the alert to be active, and a later read on its own to clear it. A mode write or a general reset can also coincide with a partly built consecutive count. The bench builds a partial count, changes the mode, and shows that the count had to be rebuilt in full.

// File: rtl/thermal_alert_pkg.sv
package thermal_alert_pkg;

  localparam int TEMP_W_DEF = 16;
  localparam int CF_W_DEF   = 2;

  // map a logical alert state onto a line level for the chosen polarity
  function automatic logic polarize(input logic active, input logic pol);
    return pol ? active : ~active;
  endfunction

endpackage

// File: rtl/ta_threshold_cmp.sv
module ta_threshold_cmp #(
  parameter int TEMP_W = 16
) (
  input  logic [TEMP_W-1:0] value,
  input  logic [TEMP_W-1:0] thr_low,
  input  logic [TEMP_W-1:0] thr_high,
  output logic              at_high,
  output logic              at_low
);

  function automatic logic s_ge(input logic [TEMP_W-1:0] a, input logic [TEMP_W-1:0] b);
    return $signed(a) >= $signed(b);
  endfunction

  function automatic logic s_le(input logic [TEMP_W-1:0] a, input logic [TEMP_W-1:0] b);
    return $signed(a) <= $signed(b);
  endfunction

  assign at_high = s_ge(value, thr_high);
  assign at_low  = s_le(value, thr_low);

  // R10
  always_comb begin
    both_hit_order_chk : assert (!(at_high && at_low) || ($signed(thr_low) >= $signed(thr_high)));
  end

endmodule

// File: rtl/ta_fault_debounce.sv
module ta_fault_debounce #(
  parameter int CF_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            sample,
  input  logic            meets_high,
  input  logic            meets_low,
  input  logic [CF_W-1:0] cf,
  output logic            hot,
  output logic            flip
);

  localparam int NEED_W = CF_W + 1;

  logic [CF_W-1:0]   cnt_q;
  logic              hot_q;
  logic              hit;
  logic [NEED_W-1:0] need;
  logic [NEED_W-1:0] run;

  assign hit  = hot_q ? meets_low : meets_high;
  assign need = {1'b0, cf} + NEED_W'(1);
  assign run  = {1'b0, cnt_q} + NEED_W'(1);
  assign flip = sample & hit & (run >= need) & ~flush;
  assign hot  = hot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      hot_q <= 1'b0;
    end else if (flush) begin
      cnt_q <= '0;
      hot_q <= 1'b0;
    end else if (sample) begin
      if (!hit) begin
        cnt_q <= '0;
      end else if (flip) begin
        cnt_q <= '0;
        hot_q <= ~hot_q;
      end else begin
        cnt_q <= run[CF_W-1:0];
      end
    end
  end

  // R3
  miss_clears_count_chk : assert property (@(posedge clk) disable iff (!rst_n)
    (sample && !hit && !flush) |=> (cnt_q == '0));

  // R2
  hot_moves_on_sample_chk : assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hot_q) |-> $past(sample || flush));

endmodule

// File: rtl/thermal_alert.sv
module thermal_alert
  import thermal_alert_pkg::*;
#(
  parameter int TEMP_W = TEMP_W_DEF,
  parameter int CF_W   = CF_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_im_wr,
  input  logic              cfg_im_wdata,
  input  logic              cfg_pol,
  input  logic [CF_W-1:0]   cfg_cf,
  input  logic              cfg_sleep,
  input  logic [TEMP_W-1:0] thr_low,
  input  logic [TEMP_W-1:0] thr_high,
  input  logic              res_valid,
  input  logic [TEMP_W-1:0] res_value,
  input  logic              reg_read,
  input  logic              gen_reset,
  output logic              alert_pin,
  output logic              alert_status,
  output logic              im_mode
);

  logic im_q;
  logic int_q;
  logic sleep_q;
  logic at_high;
  logic at_low;
  logic hot;
  logic flip;
  logic mode_chg;
  logic sleep_rise;
  logic int_clr;
  logic active;

  assign mode_chg   = gen_reset ? im_q : (cfg_im_wr && (cfg_im_wdata != im_q));
  assign sleep_rise = cfg_sleep & ~sleep_q;
  assign int_clr    = reg_read | sleep_rise;

  ta_threshold_cmp #(.TEMP_W(TEMP_W)) u_cmp (
    .value    (res_value),
    .thr_low  (thr_low),
    .thr_high (thr_high),
    .at_high  (at_high),
    .at_low   (at_low)
  );

  ta_fault_debounce #(.CF_W(CF_W)) u_deb (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (mode_chg),
    .sample     (res_valid),
    .meets_high (at_high),
    .meets_low  (at_low),
    .cf         (cfg_cf),
    .hot        (hot),
    .flip       (flip)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      im_q    <= 1'b0;
      sleep_q <= 1'b0;
    end else begin
      sleep_q <= cfg_sleep;
      if (gen_reset)      im_q <= 1'b0;
      else if (cfg_im_wr) im_q <= cfg_im_wdata;
    end
  end

  // interrupt latch: a new tracker change outranks a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                int_q <= 1'b0;
    else if (mode_chg)         int_q <= 1'b0;
    else if (im_q && flip)     int_q <= 1'b1;
    else if (int_clr)          int_q <= 1'b0;
  end

  assign active       = im_q ? int_q : hot;
  assign alert_pin    = polarize(active, cfg_pol);
  assign alert_status = polarize(hot, cfg_pol);
  assign im_mode      = im_q;

  // R11
  greset_clears_mode_chk : assert property (@(posedge clk) disable iff (!rst_n)
    gen_reset |=> !im_mode);

  // R5
  read_clears_latch_chk : assert property (@(posedge clk) disable iff (!rst_n)
    (im_q && int_q && reg_read && !flip && !mode_chg) |=> !int_q);

  // R7
  sleep_entry_clears_chk : assert property (@(posedge clk) disable iff (!rst_n)
    (im_q && int_q && sleep_rise && !flip && !mode_chg) |=> !int_q);

  // R12
  latch_needs_change_chk : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_q) |-> $past(flip));

  // R9
  status_tracks_line_chk : assert property (@(posedge clk) disable iff (!rst_n)
    !im_q |-> (alert_pin == alert_status));

endmodule

// File: tb/thermal_alert_tb.sv
module thermal_alert_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_im_wr = 1'b0;
  logic        cfg_im_wdata = 1'b0;
  logic        cfg_pol = 1'b0;
  logic [1:0]  cfg_cf = 2'b00;
  logic        cfg_sleep = 1'b0;
  logic [15:0] thr_low = 16'h2580;
  logic [15:0] thr_high = 16'h2800;
  logic        res_valid = 1'b0;
  logic [15:0] res_value = 16'h0000;
  logic        reg_read = 1'b0;
  logic        gen_reset = 1'b0;
  logic        alert_pin;
  logic        alert_status;
  logic        im_mode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  thermal_alert u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_im_wr    (cfg_im_wr),
    .cfg_im_wdata (cfg_im_wdata),
    .cfg_pol      (cfg_pol),
    .cfg_cf       (cfg_cf),
    .cfg_sleep    (cfg_sleep),
    .thr_low      (thr_low),
    .thr_high     (thr_high),
    .res_valid    (res_valid),
    .res_value    (res_value),
    .reg_read     (reg_read),
    .gen_reset    (gen_reset),
    .alert_pin    (alert_pin),
    .alert_status (alert_status),
    .im_mode      (im_mode)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // line level for a logical alert state
  function automatic logic lvl(input logic on, input logic pol);
    return (on == pol);
  endfunction

  task automatic push(input logic [15:0] v);
    @(negedge clk); res_valid = 1'b1; res_value = v;
    @(negedge clk); res_valid = 1'b0;
  endtask

  task automatic do_read();
    @(negedge clk); reg_read = 1'b1;
    @(negedge clk); reg_read = 1'b0;
  endtask

  task automatic write_mode(input logic m);
    @(negedge clk); cfg_im_wr = 1'b1; cfg_im_wdata = m;
    @(negedge clk); cfg_im_wr = 1'b0;
  endtask

  task automatic t_reset();
    chk(alert_pin, 1'b1, "R1 line after reset");
    chk(alert_status, 1'b1, "R1 status after reset");
    chk(im_mode, 1'b0, "R1 mode after reset");
  endtask

  task automatic t_comparator();
    cfg_cf = 2'b10;
    push(16'h2800); push(16'h2800);
    chk(alert_pin, 1'b1, "R2 two of three");
    push(16'h2700);
    chk(alert_pin, 1'b1, "R3 miss");
    push(16'h2800); push(16'h2800);
    chk(alert_pin, 1'b1, "R3 count restarted");
    push(16'h2900);
    chk(alert_pin, 1'b0, "R4 third high result");
    chk(alert_status, 1'b0, "R9 status equals line");
    push(16'h2600);
    chk(alert_pin, 1'b0, "R4 hold between thresholds");
    push(16'h2580); push(16'h2580);
    chk(alert_pin, 1'b0, "R4 two low results");
    push(16'h2000);
    chk(alert_pin, 1'b1, "R4 release after third low");
  endtask

  task automatic t_signed();
    cfg_cf = 2'b00;
    thr_high = 16'h0010;
    thr_low = 16'h0000;
    push(16'hEC00);
    chk(alert_pin, 1'b1, "R10 negative below high");
    push(16'h0010);
    chk(alert_pin, 1'b0, "R10 equal meets high");
    thr_low = 16'hF000;
    push(16'hFF00);
    chk(alert_pin, 1'b0, "R10 -2C above -32C low");
    push(16'hEC00);
    chk(alert_pin, 1'b1, "R10 -40C below low");
    thr_low = 16'h2580;
    thr_high = 16'h2800;
  endtask

  task automatic t_polarity();
    @(negedge clk); cfg_pol = 1'b1;
    #1;
    chk(alert_pin, 1'b0, "R8 idle active-high");
    chk(alert_status, 1'b0, "R9 idle status active-high");
    push(16'h2800);
    chk(alert_pin, 1'b1, "R8 alert active-high");
    chk(alert_status, 1'b1, "R9 status active-high");
    @(negedge clk); cfg_pol = 1'b0;
    #1;
    chk(alert_pin, 1'b0, "R8 alert active-low");
    push(16'h2000);
    chk(alert_pin, 1'b1, "R8 released active-low");
  endtask

  task automatic t_mode_change();
    cfg_cf = 2'b01;
    push(16'h2800);
    write_mode(1'b1);
    chk(im_mode, 1'b1, "R11 mode written");
    push(16'h2800);
    chk(alert_pin, 1'b1, "R11 count cleared by mode change");
    push(16'h2800);
    chk(alert_pin, 1'b0, "R5 interrupt latched");
    chk(alert_status, 1'b0, "R9 status from tracker");
  endtask

  task automatic t_interrupt();
    push(16'h2900);
    chk(alert_pin, 1'b0, "R5 stays latched");
    do_read();
    chk(alert_pin, 1'b1, "R5 read clears");
    push(16'h2900); push(16'h2900);
    chk(alert_pin, 1'b1, "R6 high ignored after high event");
    chk(alert_status, 1'b0, "R6 tracker still high");
    push(16'h2580);
    chk(alert_pin, 1'b1, "R6 one low result");
    push(16'h2400);
    chk(alert_pin, 1'b0, "R6 low event latches");
    chk(alert_status, 1'b1, "R9 tracker low");
    do_read();
    chk(alert_pin, 1'b1, "R5 read clears low event");
  endtask

  task automatic t_sleep();
    push(16'h2800); push(16'h2800);
    chk(alert_pin, 1'b0, "R7 setup latched");
    @(negedge clk); cfg_sleep = 1'b1;
    @(negedge clk);
    chk(alert_pin, 1'b1, "R7 sleep entry clears");
    push(16'h2000); push(16'h2000);
    chk(alert_pin, 1'b0, "R7 held sleep does not clear");
    @(negedge clk); cfg_sleep = 1'b0;
    do_read();
    chk(alert_pin, 1'b1, "R7 read after wake");
  endtask

  task automatic t_same_cycle();
    cfg_cf = 2'b00;
    @(negedge clk); res_valid = 1'b1; res_value = 16'h2800; reg_read = 1'b1;
    @(negedge clk); res_valid = 1'b0; reg_read = 1'b0;
    chk(alert_pin, 1'b0, "R12 change wins over read");
    do_read();
    chk(alert_pin, 1'b1, "R12 later read clears");
  endtask

  task automatic t_general_reset();
    push(16'h2000);
    chk(alert_pin, 1'b0, "R11 setup low event");
    do_read();
    push(16'h2800);
    chk(alert_status, 1'b0, "R11 setup tracker high");
    @(negedge clk); gen_reset = 1'b1;
    @(negedge clk); gen_reset = 1'b0;
    chk(im_mode, 1'b0, "R11 general reset clears mode");
    chk(alert_pin, lvl(1'b0, 1'b0), "R11 line inactive");
    chk(alert_status, 1'b1, "R11 tracker cleared");
    push(16'h2800);
    chk(alert_pin, 1'b0, "R11 comparator mode after reset");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_comparator();
    t_signed();
    t_polarity();
    t_mode_change();
    t_interrupt();
    t_sleep();
    t_same_cycle();
    t_general_reset();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule